// File: doc/BRIEF.md
# Fractional-N Divider Modulus Controller

This block divides an input clock by an average ratio of N + F/D. A first-order fractional accumulator picks a whole ratio for each output period, either N or N+1. That whole ratio is built by steering a digitally modelled four-modulus prescaler through its moduli P, P+1, P+4 and P+5. Two bands are offered:

- **High band:** P = 16, with N from 80 to 32767.
- **Low band:** P = 8, with N from 40 to 16383.

The fractional denominator D is either 15 or 16. That choice covers fractions with denominators 1, 2, 3, 4, 5, 8, 15 and 16.

The control logic samples the settings only at an output-period boundary. The boundaries are the first enabled cycle after reset and the last input cycle of every period. A set of settings that is out of range is flagged and then ignored. Driving the enable low freezes the whole block, as a power-down hold.

Top module: `fracn_div`

## Requirements
- R1: While reset is asserted, and until the first cycle with `en` high, `div_pulse` stays low and `mod_sel` reads 2'b00.
- R2: Each output period lasts N or N+1 enabled input cycles, and `div_pulse` is high only in its last cycle. At each boundary the accumulator `acc` is updated as follows. If acc+F ≥ D, the period is N+1 and acc becomes acc+F−D. Otherwise the period is N and acc becomes acc+F.
- R3: After reset the accumulator is zero, and the first output period lasts exactly N cycles.
- R4: `den15`=1 selects D=15 and `den15`=0 selects D=16. With settings held fixed, exactly F of D consecutive periods that start right after reset last N+1 cycles.
- R5: The `mod_sel` encoding is: bit0 set means the P+1 step, bit1 set means the P+4 step, 2'b11 means P+5 and 2'b00 means P. For a period of length T:
  - Take P = 16 when `band_hi`=1 and P = 8 otherwise.
  - Let B = T div P, A = (T mod P) mod 4 and C = (T mod P) div 4.
  - The first min(A,C) prescaler cycles run at P+5.
  - The remaining A or C cycles then run at P+1 or P+4 respectively.
  - The rest run at P.
  - After a code of 2'b00 appears within a period, the code stays 2'b00 until that period ends.
- R6: `cfg_err` is high in any of these cases:
  - `band_hi`=1 and N is outside 80..32767.
  - `band_hi`=0 and N is outside 40..16383.
  - F ≥ D.

  In every other case `cfg_err` is low.
- R7: If the settings sampled at a boundary are invalid under R6, the boundary keeps the previous N, F, D and band unchanged.
- R8: N, F, D and band are sampled only at a boundary. A change made in the middle of a period does not alter that period's length.
- R9: While `en` is low, the counters, the accumulator and `mod_sel` hold and `div_pulse` stays low. After `en` returns high, the period resumes where it stopped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Input clock to be divided |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| en | input | 1 | Run enable; low holds every counter |
| band_hi | input | 1 | 1: prescaler base 16, 0: base 8 |
| n_int | input | 15 | Integer divide ratio N |
| frac_num | input | 4 | Fractional numerator F |
| den15 | input | 1 | 1: D=15, 0: D=16 |
| div_pulse | output | 1 | One-cycle pulse ending each output period |
| mod_sel | output | 2 | Current prescaler modulus select |
| cfg_err | output | 1 | Settings at the inputs are out of range |

## Verification
The bench builds the block with its default parameters: prescaler bases 16 and 8, and ratio windows 80..32767 and 40..16383. These defaults make both band edges reachable, including the largest ratio of 32768 (32767 plus a carry). Both accumulator wrap points, 15 and 16, can be exercised. Every prescaler step mix can be reached, from all-P+5 groups to plain P cycles. Random settings, including some with invalid N, are changed without reset, so boundary sampling and invalid-set retention are checked while the divider is running.

// File: rtl/fracn_pkg.sv
package fracn_pkg;
  localparam int unsigned NW = 15;
  localparam int unsigned FW = 4;

  typedef enum logic [1:0] {
    MS_BASE  = 2'b00,
    MS_PLUS1 = 2'b01,
    MS_PLUS4 = 2'b10,
    MS_PLUS5 = 2'b11
  } msel_e;

  typedef struct packed {
    logic          hi;
    logic [NW-1:0] n;
    logic [FW-1:0] f;
    logic          d15;
  } fcfg_t;
endpackage

// File: rtl/fracn_rst_sync.sv
module fracn_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic srst_n
);
  logic s1_q, s2_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s1_q <= 1'b0;
      s2_q <= 1'b0;
    end else begin
      s1_q <= 1'b1;
      s2_q <= s1_q;
    end
  end

  assign srst_n = s2_q;
endmodule

// File: rtl/fracn_cfg_check.sv
module fracn_cfg_check
  import fracn_pkg::*;
#(
  parameter int unsigned N_MIN_HI = 80,
  parameter int unsigned N_MAX_HI = 32767,
  parameter int unsigned N_MIN_LO = 40,
  parameter int unsigned N_MAX_LO = 16383
) (
  input  fcfg_t cfg,
  output logic  ok
);
  localparam logic [NW-1:0] MIN_HI = N_MIN_HI[NW-1:0];
  localparam logic [NW-1:0] MAX_HI = N_MAX_HI[NW-1:0];
  localparam logic [NW-1:0] MIN_LO = N_MIN_LO[NW-1:0];
  localparam logic [NW-1:0] MAX_LO = N_MAX_LO[NW-1:0];

  logic [NW-1:0] lo_lim, hi_lim;
  logic [FW:0]   den;
  logic          n_ok, f_ok;

  always_comb begin
    lo_lim = cfg.hi ? MIN_HI : MIN_LO;
    hi_lim = cfg.hi ? MAX_HI : MAX_LO;
    den    = cfg.d15 ? 5'd15 : 5'd16;
    n_ok   = (cfg.n >= lo_lim) && (cfg.n <= hi_lim);
    f_ok   = {1'b0, cfg.f} < den;
    ok     = n_ok && f_ok;
  end
endmodule

// File: rtl/fracn_accum.sv
module fracn_accum
  import fracn_pkg::*;
(
  input  logic          clk,
  input  logic          rst_n,
  input  logic          step,
  input  logic [FW-1:0] f,
  input  logic          d15,
  output logic          carry,
  output logic [FW-1:0] acc_o
);
  logic [FW-1:0] acc_q, acc_d;
  logic [FW:0]   sum, den;

  always_comb begin
    den   = d15 ? 5'd15 : 5'd16;
    sum   = {1'b0, acc_q} + {1'b0, f};
    carry = (sum >= den);
    acc_d = acc_q;
    if (step) begin
      if (carry) acc_d = FW'(sum - den);
      else       acc_d = sum[FW-1:0];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) acc_q <= '0;
    else        acc_q <= acc_d;
  end

  assign acc_o = acc_q;
endmodule

// File: rtl/fracn_presc_seq.sv
module fracn_presc_seq
  import fracn_pkg::*;
#(
  parameter int unsigned P_HI = 16,
  parameter int unsigned P_LO = 8
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        en,
  input  logic        load,
  input  logic        hi,
  input  logic [NW:0] total,
  output logic        last,
  output msel_e       msel
);
  localparam int unsigned PH_SH = $clog2(P_HI);
  localparam int unsigned PL_SH = $clog2(P_LO);
  localparam int unsigned BW    = NW + 1 - PL_SH;
  localparam int unsigned PCW   = $clog2(P_HI + 6);
  localparam logic [3:0]  MASK_HI = 4'(P_HI - 1);
  localparam logic [3:0]  MASK_LO = 4'(P_LO - 1);

  logic          hi_q, hi_d;
  logic [BW-1:0] b_q, b_d, bidx_q, bidx_d, bidx_nx;
  logic [1:0]    a_q, a_d, c_q, c_d;
  logic [PCW-1:0] pcnt_q, pcnt_d;

  logic [BW-1:0] ld_b;
  logic [3:0]    rem4;
  logic [1:0]    ld_a, ld_c;

  function automatic logic [PCW-1:0] mod_m1(input logic h, input logic la, input logic lc);
    logic [PCW-1:0] m;
    m = h ? PCW'(P_HI - 1) : PCW'(P_LO - 1);
    if (la) m = m + PCW'(1);
    if (lc) m = m + PCW'(4);
    return m;
  endfunction

  always_comb begin
    ld_b = hi ? BW'(total >> PH_SH) : BW'(total >> PL_SH);
    rem4 = total[3:0] & (hi ? MASK_HI : MASK_LO);
    ld_a = rem4[1:0];
    ld_c = rem4[3:2];
  end

  assign last    = (pcnt_q == '0) && (bidx_q == b_q - BW'(1));
  assign bidx_nx = bidx_q + BW'(1);

  always_comb begin
    hi_d   = hi_q;
    b_d    = b_q;
    a_d    = a_q;
    c_d    = c_q;
    bidx_d = bidx_q;
    pcnt_d = pcnt_q;
    if (load) begin
      hi_d   = hi;
      b_d    = ld_b;
      a_d    = ld_a;
      c_d    = ld_c;
      bidx_d = '0;
      pcnt_d = mod_m1(hi, ld_a != 2'd0, ld_c != 2'd0);
    end else if (en) begin
      if (pcnt_q != '0) begin
        pcnt_d = pcnt_q - PCW'(1);
      end else if (!last) begin
        bidx_d = bidx_nx;
        pcnt_d = mod_m1(hi_q, bidx_nx < BW'(a_q), bidx_nx < BW'(c_q));
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hi_q   <= 1'b0;
      b_q    <= '0;
      a_q    <= '0;
      c_q    <= '0;
      bidx_q <= '0;
      pcnt_q <= '0;
    end else begin
      hi_q   <= hi_d;
      b_q    <= b_d;
      a_q    <= a_d;
      c_q    <= c_d;
      bidx_q <= bidx_d;
      pcnt_q <= pcnt_d;
    end
  end

  assign msel = msel_e'({bidx_q < BW'(c_q), bidx_q < BW'(a_q)});
endmodule

// File: rtl/fracn_div.sv
module fracn_div
  import fracn_pkg::*;
#(
  parameter int unsigned P_HI     = 16,
  parameter int unsigned P_LO     = 8,
  parameter int unsigned N_MIN_HI = 80,
  parameter int unsigned N_MAX_HI = 32767,
  parameter int unsigned N_MIN_LO = 40,
  parameter int unsigned N_MAX_LO = 16383
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          en,
  input  logic          band_hi,
  input  logic [NW-1:0] n_int,
  input  logic [FW-1:0] frac_num,
  input  logic          den15,
  output logic          div_pulse,
  output logic [1:0]    mod_sel,
  output logic          cfg_err
);
  logic          srst_n;
  fcfg_t         cfg_in, cfg_q, cfg_d, cfg_nx;
  logic          in_ok, armed_q, armed_d, bnd, last, carry;
  logic [NW:0]   total;
  logic [FW-1:0] acc_w;
  msel_e         msel_w;

  fracn_rst_sync u_rst (.clk(clk), .rst_n(rst_n), .srst_n(srst_n));

  assign cfg_in = '{hi: band_hi, n: n_int, f: frac_num, d15: den15};

  fracn_cfg_check #(
    .N_MIN_HI(N_MIN_HI), .N_MAX_HI(N_MAX_HI),
    .N_MIN_LO(N_MIN_LO), .N_MAX_LO(N_MAX_LO)
  ) u_chk_in (.cfg(cfg_in), .ok(in_ok));

  always_comb begin
    bnd     = en && (!armed_q || last);
    cfg_nx  = in_ok ? cfg_in : cfg_q;
    cfg_d   = bnd ? cfg_nx : cfg_q;
    armed_d = armed_q || en;
    total   = {1'b0, cfg_nx.n} + {{NW{1'b0}}, carry};
  end

  always_ff @(posedge clk or negedge srst_n) begin
    if (!srst_n) begin
      armed_q <= 1'b0;
      cfg_q   <= '{hi: 1'b0, n: N_MIN_LO[NW-1:0], f: '0, d15: 1'b0};
    end else begin
      armed_q <= armed_d;
      cfg_q   <= cfg_d;
    end
  end

  fracn_accum u_acc (
    .clk(clk), .rst_n(srst_n), .step(bnd),
    .f(cfg_nx.f), .d15(cfg_nx.d15), .carry(carry), .acc_o(acc_w)
  );

  fracn_presc_seq #(.P_HI(P_HI), .P_LO(P_LO)) u_seq (
    .clk(clk), .rst_n(srst_n), .en(en), .load(bnd),
    .hi(cfg_nx.hi), .total(total), .last(last), .msel(msel_w)
  );

  assign div_pulse = armed_q && en && last;
  assign mod_sel   = msel_w;
  assign cfg_err   = !in_ok;
endmodule

// File: rtl/fracn_div_chk.sv
module fracn_div_chk #(
  parameter int unsigned NW       = 15,
  parameter int unsigned N_MIN_HI = 80
) (
  input logic          clk,
  input logic          rst_n,
  input logic          en,
  input logic          band_hi,
  input logic [NW-1:0] n_int,
  input logic          div_pulse,
  input logic [1:0]    mod_sel,
  input logic          cfg_err,
  input logic          armed,
  input logic [3:0]    acc,
  input logic          d15_act
);
  // R1
  idle_sel_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !armed |-> mod_sel == 2'b00);

  // R2
  single_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    div_pulse |=> !div_pulse);

  // R4
  acc_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    {1'b0, acc} < (d15_act ? 5'd15 : 5'd16));

  // R5
  base_tail_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (armed && en && !div_pulse && mod_sel == 2'b00) |=> mod_sel == 2'b00);

  // R6
  low_n_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (band_hi && n_int < N_MIN_HI[NW-1:0]) |-> cfg_err);

  // R9
  hold_sel_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !en |=> $stable(mod_sel));
endmodule

bind fracn_div fracn_div_chk #(.NW(15), .N_MIN_HI(N_MIN_HI)) u_div_chk (
  .clk(clk), .rst_n(rst_n), .en(en), .band_hi(band_hi), .n_int(n_int),
  .div_pulse(div_pulse), .mod_sel(mod_sel), .cfg_err(cfg_err),
  .armed(armed_q), .acc(acc_w), .d15_act(cfg_q.d15)
);

// File: tb/fracn_div_bench.sv
module fracn_div_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        en = 1'b0;
  logic        band_hi = 1'b0;
  logic [14:0] n_int = 15'd40;
  logic [3:0]  frac_num = 4'd0;
  logic        den15 = 1'b0;
  wire         div_pulse;
  wire  [1:0]  mod_sel;
  wire         cfg_err;

  always #5 clk = ~clk;

  fracn_div u_fracn_div (
    .clk(clk), .rst_n(rst_n), .en(en), .band_hi(band_hi), .n_int(n_int),
    .frac_num(frac_num), .den15(den15), .div_pulse(div_pulse),
    .mod_sel(mod_sel), .cfg_err(cfg_err)
  );

  int total_chk = 0;
  int bad_chk = 0;

  task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
    total_chk++;
    if (!ok) begin
      bad_chk++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  function automatic bit valid_set(input bit hi, input int n, input int f, input bit d15);
    int lo, up, d;
    lo = hi ? 80 : 40;
    up = hi ? 32767 : 16383;
    d  = d15 ? 15 : 16;
    return (n >= lo) && (n <= up) && (f < d);
  endfunction

  // model state
  bit m_armed, m_hi, m_d15, exp_long, first_per, per_hi;
  int m_n, m_f, m_acc, exp_tot, exp_a, exp_b, exp_c, per_n, first_n;
  int cnt, npulse, meas_long, last_cnt;
  int codes[4];

  task automatic model_boundary();
    int d, s, p, r;
    if (valid_set(band_hi, int'(n_int), int'(frac_num), den15)) begin
      m_hi = band_hi; m_n = int'(n_int); m_f = int'(frac_num); m_d15 = den15;
    end
    d = m_d15 ? 15 : 16;
    s = m_acc + m_f;
    exp_long = (s >= d);
    m_acc = exp_long ? s - d : s;
    exp_tot = m_n + (exp_long ? 1 : 0);
    p = m_hi ? 16 : 8;
    exp_b = exp_tot / p;
    r = exp_tot % p;
    exp_a = r % 4;
    exp_c = r / 4;
    per_n = m_n;
    per_hi = m_hi;
  endtask

  always @(negedge clk) begin
    if (!rst_n) begin
      m_armed = 0; m_hi = 0; m_n = 40; m_f = 0; m_d15 = 0; m_acc = 0;
      cnt = 0; first_per = 1;
      for (int i = 0; i < 4; i++) codes[i] = 0;
    end else if (en) begin
      if (!m_armed) begin
        m_armed = 1;
        model_boundary();
        first_n = m_n;
        cnt = 0;
        for (int i = 0; i < 4; i++) codes[i] = 0;
      end else begin
        cnt++;
        codes[mod_sel]++;
        if (div_pulse) begin
          int p, mn, mx;
          p  = per_hi ? 16 : 8;
          mn = (exp_a < exp_c) ? exp_a : exp_c;
          mx = (exp_a < exp_c) ? exp_c : exp_a;
          chk(cnt == exp_tot, "R2 period length", cnt, exp_tot);
          if (first_per) begin
            chk(cnt == first_n, "R3 first period after reset", cnt, first_n);
            first_per = 0;
          end
          chk(codes[3] == mn * (p + 5), "R5 P+5 cycles", codes[3], mn * (p + 5));
          chk(codes[1] == (exp_a - mn) * (p + 1), "R5 P+1 cycles", codes[1], (exp_a - mn) * (p + 1));
          chk(codes[2] == (exp_c - mn) * (p + 4), "R5 P+4 cycles", codes[2], (exp_c - mn) * (p + 4));
          chk(codes[0] == (exp_b - mx) * p, "R5 base cycles", codes[0], (exp_b - mx) * p);
          if (cnt == per_n + 1) meas_long++;
          last_cnt = cnt;
          npulse++;
          cnt = 0;
          for (int i = 0; i < 4; i++) codes[i] = 0;
          model_boundary();
        end
      end
    end else if (div_pulse) begin
      chk(0, "R9 pulse while disabled", 1, 0);
    end
  end

  task automatic apply(input bit hi, input int n, input int f, input bit d15);
    @(posedge clk); #1;
    band_hi = hi; n_int = 15'(n); frac_num = 4'(f); den15 = d15;
  endtask

  task automatic wait_pulses(input int k);
    int tgt;
    tgt = npulse + k;
    while (npulse < tgt) begin
      @(negedge clk); #1;
    end
  endtask

  task automatic do_reset(input bit hi, input int n, input int f, input bit d15);
    @(posedge clk); #1;
    rst_n = 0; en = 0;
    band_hi = hi; n_int = 15'(n); frac_num = 4'(f); den15 = d15;
    repeat (3) @(posedge clk);
    #1 rst_n = 1;
    repeat (4) @(posedge clk);
    #1 en = 1;
  endtask

  task automatic avg_case(input bit hi, input int n, input int f, input bit d15);
    int ml0, d;
    d = d15 ? 15 : 16;
    do_reset(hi, n, f, d15);
    ml0 = meas_long;
    wait_pulses(d);
    chk(meas_long - ml0 == f, "R4 long periods per D window", meas_long - ml0, f);
  endtask

  initial begin
    repeat (199000) @(posedge clk);
    chk(0, "watchdog expired", 0, 1);
    $display("test done: total=%0d bad=%0d", total_chk, bad_chk);
    $finish;
  end

  initial begin
    npulse = 0; meas_long = 0; last_cnt = 0;
    void'($urandom(32'd20240611));

    // R1 reset state
    repeat (3) @(negedge clk);
    chk(div_pulse == 1'b0, "R1 pulse low in reset", div_pulse, 0);
    chk(mod_sel == 2'b00, "R1 select idle in reset", mod_sel, 0);
    #1 rst_n = 1;
    repeat (5) @(negedge clk);
    chk(div_pulse == 1'b0, "R1 pulse low before enable", div_pulse, 0);
    chk(mod_sel == 2'b00, "R1 select idle before enable", mod_sel, 0);

    // R6 flag values, block held disabled
    apply(1, 79, 0, 0);  #1 chk(cfg_err == 1, "R6 high band N=79", cfg_err, 1);
    apply(1, 80, 0, 0);  #1 chk(cfg_err == 0, "R6 high band N=80", cfg_err, 0);
    apply(1, 32767, 15, 0); #1 chk(cfg_err == 0, "R6 high band N=32767", cfg_err, 0);
    apply(0, 16384, 0, 0); #1 chk(cfg_err == 1, "R6 low band N=16384", cfg_err, 1);
    apply(0, 39, 0, 0);  #1 chk(cfg_err == 1, "R6 low band N=39", cfg_err, 1);
    apply(0, 100, 15, 1); #1 chk(cfg_err == 1, "R6 F=15 with D=15", cfg_err, 1);
    apply(0, 100, 14, 1); #1 chk(cfg_err == 0, "R6 F=14 with D=15", cfg_err, 0);

    // plain integer runs at band minimums (R2, R3, R5)
    do_reset(0, 40, 0, 0);
    wait_pulses(3);
    do_reset(1, 80, 0, 0);
    wait_pulses(3);

    // R4 averages for both denominators
    avg_case(1, 100, 5, 1);
    avg_case(1, 80, 15, 0);
    avg_case(0, 41, 3, 0);
    avg_case(0, 203, 14, 1);
    avg_case(1, 117, 8, 0);

    // R7 invalid settings at a boundary are ignored
    do_reset(0, 50, 0, 0);
    wait_pulses(2);
    apply(0, 30, 0, 0);
    wait_pulses(3);
    chk(last_cnt == 50, "R7 invalid N keeps previous ratio", last_cnt, 50);
    chk(cfg_err == 1, "R6 flag for N=30 low band", cfg_err, 1);

    // R8 mid-period change waits for boundary
    do_reset(0, 60, 0, 0);
    wait_pulses(1);
    repeat (10) @(posedge clk);
    apply(0, 90, 0, 0);
    wait_pulses(1);
    chk(last_cnt == 60, "R8 period in flight keeps old N", last_cnt, 60);
    wait_pulses(1);
    chk(last_cnt == 90, "R8 new N after boundary", last_cnt, 90);

    // R9 enable low freezes state
    begin
      logic [1:0] ms;
      int np0;
      do_reset(1, 100, 0, 0);
      wait_pulses(1);
      repeat (7) @(posedge clk);
      #1 en = 0;
      @(negedge clk);
      ms = mod_sel;
      np0 = npulse;
      repeat (25) @(negedge clk);
      chk(mod_sel == ms, "R9 select frozen while disabled", mod_sel, ms);
      chk(npulse == np0, "R9 no pulses while disabled", npulse, np0);
      @(posedge clk); #1 en = 1;
      wait_pulses(1);
      chk(last_cnt == 100, "R9 period resumes after enable", last_cnt, 100);
    end

    // band maximums
    do_reset(1, 32767, 1, 0);
    wait_pulses(2);
    do_reset(0, 16383, 0, 0);
    wait_pulses(2);

    // constrained random settings without reset
    do_reset(0, 45, 1, 0);
    for (int k = 0; k < 30; k++) begin
      bit hi, d15;
      int n, f, lo;
      hi  = bit'($urandom % 2);
      lo  = hi ? 80 : 40;
      n   = lo + int'($urandom % 150);
      if ($urandom % 8 == 0) n = lo - 1 - int'($urandom % 10);
      d15 = bit'($urandom % 2);
      f   = int'($urandom % (d15 ? 15 : 16));
      apply(hi, n, f, d15);
      wait_pulses(1 + int'($urandom % 6));
    end

    $display("test done: total=%0d bad=%0d", total_chk, bad_chk);
    $finish;
  end
endmodule